// File: doc/BRIEF.md
# Digital PLL Bit Clock Recovery

This block recovers the bit timing of a serial NRZ or NRZI line. It runs from a reference clock at sixteen times the nominal bit rate. A four-bit phase counter divides each bit period into sixteen slots. The block samples the line at a fixed slot of that period. When a data transition arrives, the slot it falls in decides the action: the next sample is moved one reference clock later, moved one reference clock earlier, jumped by half a bit, or left alone.

The half-bit jump lets the loop lock on a single transition, so no preamble is needed. A control input turns the jump off. The adjust windows then widen over the slots the jump used, which makes the loop less sensitive to jitter but slower to converge. After an accepted transition, further transitions within sixteen reference clocks are treated as interference. Downstream logic takes the sampled bit whenever the valid pulse is high and can use the square-wave bit clock as a timing reference.

Top module: `dpll_clk_recovery`

## Requirements
- R1: While `rst_i` is high the phase counter is held at 0, `valid_o`, `bit_clk_o` and `data_o` are low, and the synchronizer stages are 0. After reset is released with a steady line, `bit_clk_o` first goes high after the 8th rising edge and `valid_o` first goes high after the 9th.
- R2: With no transitions, `valid_o` is a one-cycle pulse every 16 reference clocks. It follows the edge at which the counter reads slot 8. `data_o` then holds the synchronized line value and changes only together with a `valid_o` pulse. `bit_clk_o` is high while the counter reads slots 8 to 15.
- R3: `rxd_i` passes through two synchronizing flops. A transition is a difference between the synchronized bit and its previous value. It is evaluated at the third rising edge after the input changes, using the counter value held just before that edge (its slot).
- R4: An accepted transition in the retard field makes the counter hold its value for one cycle. The retard field is slots 2 and 5 when `ps_off_i` is 0, and slots 2 to 7 when `ps_off_i` is 1.
- R5: An accepted transition in the advance field makes the counter step by 2 instead of 1. The advance field is slots 10 to 13 when `ps_off_i` is 0, and slots 9 to 14 when `ps_off_i` is 1.
- R6: When `ps_off_i` is 0, an accepted transition in slot 3 or 4 forces an extra sample: `valid_o` goes high right after that edge and `data_o` carries the bit value from before the transition. The counter also steps by 9, which is half a bit beyond its normal step.
- R7: A transition in any other slot leaves the counter on its normal step: slots 0, 1, 6 to 9, 14 and 15 when `ps_off_i` is 0, and slots 0, 1, 8 and 15 when it is 1.
- R8: After a transition is accepted, transitions evaluated on the next 15 rising edges have no effect on the counter. A transition evaluated 16 edges later is accepted again.
- R9: A transition that falls in an ignored slot does not start the interference lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, sixteen times the bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Raw serial receive line |
| ps_off_i | input | 1 | 1 disables the half-bit jump and widens the adjust windows |
| bit_clk_o | output | 1 | Recovered bit clock, high during the second half of the period |
| data_o | output | 1 | Sampled data bit |
| valid_o | output | 1 | One-cycle pulse when `data_o` holds a new sample |

## Verification
Each line change is driven on a falling clock edge. Its slot is known because it sits a fixed number of falling edges after a regular valid pulse, at which point the counter reads slot 9. The change is evaluated on the third rising edge. A forced sample shows at the first falling edge after that edge. The next regular sample is due (8 − c) mod 16 + 2 edges later, where c is the counter value that the requirements predict for that slot. The checks count falling edges from the evaluating edge and compare the count and the sampled bit against that figure. The two lockout cases put the second transition 15 and 16 edges after the first, so an error of one cycle in the lockout length changes the measured count.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int SLOT_W      = 4;
    localparam int SLOTS       = 1 << SLOT_W;
    localparam int SAMPLE_SLOT = SLOTS / 2;
    localparam int HALF_STEP   = SLOTS / 2;

    typedef enum logic [1:0] {
        WIN_IGNORE  = 2'd0,
        WIN_RETARD  = 2'd1,
        WIN_ADVANCE = 2'd2,
        WIN_SHIFT   = 2'd3
    } win_e;

    typedef struct packed {
        logic toggled;
        logic cur_bit;
        logic old_bit;
    } line_s;

    typedef struct packed {
        logic sample;
        logic bit_val;
    } tap_s;

    function automatic win_e classify_slot(input logic [SLOT_W-1:0] slot,
                                           input logic ps_off);
        win_e w;
        w = WIN_IGNORE;
        if (ps_off) begin
            if (slot >= 4'd2 && slot <= 4'd7)       w = WIN_RETARD;
            else if (slot >= 4'd9 && slot <= 4'd14) w = WIN_ADVANCE;
        end else begin
            if (slot == 4'd3 || slot == 4'd4)        w = WIN_SHIFT;
            else if (slot == 4'd2 || slot == 4'd5)   w = WIN_RETARD;
            else if (slot >= 4'd10 && slot <= 4'd13) w = WIN_ADVANCE;
        end
        return w;
    endfunction

endpackage

// File: rtl/dpll_line_sync.sv
module dpll_line_sync
    import dpll_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  rxd_i,
    output line_s line_o
);
    logic meta_q;
    logic sync_q;
    logic hist_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= rxd_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    always_comb begin
        line_o.toggled = sync_q ^ hist_q;
        line_o.cur_bit = sync_q;
        line_o.old_bit = hist_q;
    end
endmodule

// File: rtl/dpll_lockout.sv
module dpll_lockout #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic arm_i,
    output logic busy_o
);
    localparam int TW = $clog2(LOCK_CYC);
    localparam logic [TW-1:0] RELOAD = TW'(LOCK_CYC - 1);

    logic [TW-1:0] timer_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                timer_q <= '0;
        else if (arm_i)           timer_q <= RELOAD;
        else if (timer_q != '0)   timer_q <= timer_q - 1'b1;
    end

    assign busy_o = (timer_q != '0);
endmodule

// File: rtl/dpll_phase.sv
module dpll_phase
    import dpll_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  line_s             line_i,
    input  logic              ps_off_i,
    input  logic              busy_i,
    output logic [SLOT_W-1:0] cnt_o,
    output win_e              win_o,
    output logic              accept_o,
    output tap_s              tap_o
);
    logic [SLOT_W-1:0] cnt_q;
    logic [SLOT_W-1:0] step;
    tap_s              tap_q;
    tap_s              tap_d;

    always_comb begin
        win_o    = classify_slot(cnt_q, ps_off_i);
        accept_o = line_i.toggled && !busy_i && (win_o != WIN_IGNORE);
        step     = SLOT_W'(1);
        if (accept_o) begin
            unique case (win_o)
                WIN_RETARD:  step = SLOT_W'(0);
                WIN_ADVANCE: step = SLOT_W'(2);
                WIN_SHIFT:   step = SLOT_W'(HALF_STEP + 1);
                default:     step = SLOT_W'(1);
            endcase
        end
        tap_d.sample  = 1'b0;
        tap_d.bit_val = tap_q.bit_val;
        if (accept_o && win_o == WIN_SHIFT) begin
            tap_d.sample  = 1'b1;
            tap_d.bit_val = line_i.old_bit;
        end else if (cnt_q == SLOT_W'(SAMPLE_SLOT)) begin
            tap_d.sample  = 1'b1;
            tap_d.bit_val = line_i.cur_bit;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            tap_q <= '0;
        end else begin
            cnt_q <= cnt_q + step;
            tap_q <= tap_d;
        end
    end

    assign cnt_o = cnt_q;
    assign tap_o = tap_q;
endmodule

// File: rtl/dpll_clk_recovery.sv
module dpll_clk_recovery
    import dpll_pkg::*;
#(
    parameter int LOCK_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rxd_i,
    input  logic ps_off_i,
    output logic bit_clk_o,
    output logic data_o,
    output logic valid_o
);
    line_s             line;
    logic              lock_busy;
    logic              edge_acc;
    win_e              edge_win;
    logic [SLOT_W-1:0] phase_cnt;
    tap_s              tap;

    dpll_line_sync u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .rxd_i  (rxd_i),
        .line_o (line)
    );

    dpll_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .arm_i  (edge_acc),
        .busy_o (lock_busy)
    );

    dpll_phase u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .line_i   (line),
        .ps_off_i (ps_off_i),
        .busy_i   (lock_busy),
        .cnt_o    (phase_cnt),
        .win_o    (edge_win),
        .accept_o (edge_acc),
        .tap_o    (tap)
    );

    assign bit_clk_o = (phase_cnt >= SLOT_W'(SAMPLE_SLOT));
    assign data_o    = tap.bit_val;
    assign valid_o   = tap.sample;
endmodule

// File: rtl/dpll_clk_recovery_chk.sv
module dpll_clk_recovery_chk
    import dpll_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_o,
    input logic              data_o,
    input logic              toggled,
    input logic              edge_acc,
    input win_e              edge_win,
    input logic              lock_busy,
    input logic [SLOT_W-1:0] phase_cnt
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (phase_cnt == '0) && !valid_o);

    // R2
    valid_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R2
    data_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(data_o) |-> valid_o);

    // R6
    shift_sample_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_acc && edge_win == WIN_SHIFT) |=> valid_o);

    // R8
    lock_arm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_acc |=> lock_busy);

    // R8
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (toggled && lock_busy) |=> phase_cnt == SLOT_W'($past(phase_cnt) + 1'b1));

    // R9
    ignore_noarm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (toggled && edge_win == WIN_IGNORE && !lock_busy) |=> !lock_busy);
endmodule

bind dpll_clk_recovery dpll_clk_recovery_chk u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .valid_o   (valid_o),
    .data_o    (data_o),
    .toggled   (line.toggled),
    .edge_acc  (edge_acc),
    .edge_win  (edge_win),
    .lock_busy (lock_busy),
    .phase_cnt (phase_cnt)
);

// File: tb/dpll_clk_recovery_bench.sv
`timescale 1ns/1ps
module dpll_clk_recovery_bench;
    logic clk = 1'b0;
    logic rst;
    logic rxd;
    logic ps_off;
    logic bit_clk_o;
    logic data_o;
    logic valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dpll_clk_recovery u_dpll_clk_recovery (
        .clk_i     (clk),
        .rst_i     (rst),
        .rxd_i     (rxd),
        .ps_off_i  (ps_off),
        .bit_clk_o (bit_clk_o),
        .data_o    (data_o),
        .valid_o   (valid_o)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // slot class from the requirements: 0 ignore, 1 retard, 2 advance, 3 shift
    function automatic int slot_class(input int s, input bit off);
        if (off) begin
            if (s >= 2 && s <= 7)  return 1;
            if (s >= 9 && s <= 14) return 2;
            return 0;
        end
        if (s == 3 || s == 4)    return 3;
        if (s == 2 || s == 5)    return 1;
        if (s >= 10 && s <= 13)  return 2;
        return 0;
    endfunction

    function automatic int next_due(input int c);
        return ((8 - c) % 16 + 16) % 16 + 2;
    endfunction

    task automatic wait_valid(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!valid_o && k < 40);
    endtask

    // after return the counter reads slot 9 at this falling edge
    task automatic align();
        int k;
        wait_valid(k);
    endtask

    // positions a toggle so that it is evaluated in slot s
    task automatic toggle_at(input int s);
        align();
        repeat (((s - 11) % 16 + 16) % 16) @(negedge clk);
        rxd = ~rxd;
    endtask

    task automatic t_reset();
        int k;
        bit clk_ok;
        rst = 1'b1; rxd = 1'b0; ps_off = 1'b0;
        repeat (3) @(negedge clk);
        check(!valid_o && !bit_clk_o && !data_o, "R1 reset outputs", valid_o, 0);
        rst = 1'b0;
        clk_ok = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k <= 7 && bit_clk_o) clk_ok = 1'b0;
            if (k == 8 && !bit_clk_o) clk_ok = 1'b0;
        end while (!valid_o && k < 40);
        check(k == 9, "R1 first sample edge", k, 9);
        check(clk_ok, "R1 bit clock start", clk_ok, 1);
    endtask

    task automatic t_freerun();
        int k;
        rxd = 1'b1;
        align();
        wait_valid(k);
        wait_valid(k);
        check(k == 16, "R2 sample period", k, 16);
        check(data_o == 1'b1, "R2 sampled data", data_o, 1);
        @(negedge clk);
        check(!valid_o, "R2 pulse width", valid_o, 0);
        repeat (5) @(negedge clk);
        check(bit_clk_o == 1'b1, "R2 bit clock slot 15", bit_clk_o, 1);
        @(negedge clk);
        check(bit_clk_o == 1'b0, "R2 bit clock slot 0", bit_clk_o, 0);
    endtask

    task automatic t_sweep(input bit off);
        int k;
        int cls;
        int c2;
        int expk;
        logic old_v;
        ps_off = off;
        for (int s = 0; s < 16; s++) begin
            old_v = rxd;
            toggle_at(s);
            repeat (2) @(negedge clk);
            wait_valid(k);
            cls = slot_class(s, off);
            case (cls)
                1:       c2 = s;
                2:       c2 = (s + 2) % 16;
                3:       c2 = (s + 9) % 16;
                default: c2 = (s + 1) % 16;
            endcase
            expk = (cls == 3 || s == 8) ? 1 : next_due(c2);
            case (cls)
                1: check(k == expk, $sformatf("R4 retard slot %0d off %0d", s, off), k, expk);
                2: check(k == expk, $sformatf("R5 advance slot %0d off %0d", s, off), k, expk);
                3: check(k == expk, $sformatf("R6 forced sample slot %0d", s), k, expk);
                default: check(k == expk, $sformatf("R7 ignored slot %0d off %0d (R3 timing)", s, off), k, expk);
            endcase
            if (cls == 3) begin
                check(data_o == old_v, $sformatf("R6 forced sample value slot %0d", s), data_o, old_v);
                begin
                    int k2;
                    wait_valid(k2);
                    k2 = k2 + 1;
                    check(k2 == next_due(c2), $sformatf("R6 half-bit jump slot %0d", s), k2, next_due(c2));
                end
                check(data_o == ~old_v, "R6 sample after jump", data_o, ~old_v);
            end else begin
                check(data_o == ~old_v, $sformatf("R3 sampled value slot %0d", s), data_o, ~old_v);
            end
        end
    endtask

    task automatic t_lock_fast();
        int k;
        logic old_v;
        ps_off = 1'b0;
        old_v = rxd;
        toggle_at(5);
        @(negedge clk);
        rxd = ~rxd;
        repeat (2) @(negedge clk);
        wait_valid(k);
        check(k == 4, "R8 glitch inside lockout", k, 4);
        check(data_o == old_v, "R8 glitch data", data_o, old_v);
    endtask

    task automatic t_lock_gap(input int gap);
        int k;
        ps_off = 1'b1;
        toggle_at(5);
        repeat (gap) @(negedge clk);
        rxd = ~rxd;
        repeat (2) @(negedge clk);
        wait_valid(k);
        check(k == 6, $sformatf("R8 second edge gap %0d", gap), k, 6);
    endtask

    task automatic t_noarm();
        int k;
        ps_off = 1'b0;
        toggle_at(15);
        repeat (3) @(negedge clk);
        rxd = ~rxd;
        repeat (2) @(negedge clk);
        wait_valid(k);
        check(k == 8, "R9 ignored edge leaves lockout idle", k, 8);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_freerun();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_lock_fast();
        t_lock_gap(15);
        t_lock_gap(16);
        t_noarm();
        finish_run();
    end
endmodule